// File: doc/BRIEF.md
# Watermark Result FIFO Controller

This block sits between a converter and the host readout logic. Each conversion result arrives as a single-cycle valid strobe together with its data word, and the block stores it in a first-in first-out buffer. When the number of stored results reaches a programmed watermark, an interrupt output goes high so that the host can drain the buffer through a read port. The results may come from free-running conversions or from conversions started by a synchronisation event. Both cases look the same at this block's input.

The buffer does not accept writes while the host is reading it out. A readout burst begins with the first pop of a non-empty buffer. It ends when the buffer runs empty or when the readout logic pulses an end-of-burst input. Any result that arrives during a burst is dropped. A result that arrives when the buffer is full is also dropped. Either kind of loss sets a sticky flag, which stays set until the host clears it. The read port presents the oldest stored word at all times, and a pop strobe removes that word.

Top module: `wm_result_fifo`

## Requirements
- R1: After reset the stored level is 0, `fifoEmpty` is 1, and `irq`, `readBusy` and `lostFlag` are 0.
- R2: An accepted result is stored behind all earlier ones. `rdData` always shows the oldest stored word. A pop removes that word in the clock edge where `rdPop` is sampled high.
- R3: When `cfgWatermark` is non-zero, `irq` is 1 exactly while the stored level is at least `cfgWatermark`. It drops when a pop takes the level below the watermark.
- R4: When `cfgWatermark` is 0, `irq` stays 0 at every level, including a full buffer.
- R5: A result is discarded if it arrives while `readBusy` is 1, or in the same cycle as `rdPop`. It leaves the level and the stored contents unchanged and sets `lostFlag`.
- R6: A result that arrives while the buffer holds DEPTH words is discarded and sets `lostFlag`. The stored words are unchanged.
- R7: `lostFlag` stays 1 until `lostClr` is pulsed. When a discard and `lostClr` fall in the same cycle, the flag remains 1.
- R8: `readBusy` rises after a pop that leaves the buffer non-empty. It falls after the pop that empties the buffer, or after a cycle in which `burstEnd` is 1.
- R9: A pop of an empty buffer has no effect. The level stays 0 and `readBusy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resultValid | input | 1 | One-cycle strobe for a new conversion result |
| resultData | input | DW | Result word |
| rdPop | input | 1 | Host pop strobe; removes the oldest word |
| rdData | output | DW | Oldest stored word (show-ahead) |
| burstEnd | input | 1 | Ends the current readout burst |
| cfgWatermark | input | AW+1 | Watermark level; 0 disables the interrupt |
| lostClr | input | 1 | Clears the sticky lost-result flag |
| level | output | AW+1 | Number of stored words |
| fifoEmpty | output | 1 | Buffer holds no words |
| readBusy | output | 1 | A readout burst is in progress |
| irq | output | 1 | Level has reached the watermark |
| lostFlag | output | 1 | Sticky flag: a result was discarded |

## Verification
A result can arrive in the same cycle as a pop. The pop is the start of a burst, so the drop rule applies to that result even though `readBusy` has not yet risen. The bench drives `resultValid` and `rdPop` together on a buffer with one word in it. It then checks that the popped word is the old one, that the level falls to zero and not back to one, and that `lostFlag` sets. A second case drives a discard and `lostClr` in the same cycle, and checks that the set wins.

// File: rtl/wm_result_fifo_pkg.sv
package wm_result_fifo_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobes_t;
endpackage

// File: rtl/wm_result_fifo_dp.sv
module wm_result_fifo_dp
  import wm_result_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 24,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobes_t  strobes,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] headData,
  output logic [CW-1:0] count,
  output logic          isFull,
  output logic          isEmpty
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [DW-1:0] store [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobes.push) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobes.push) wrPtr <= nextPtr(wrPtr);
      if (strobes.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strobes.push, strobes.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData = store[rdPtr];
  assign isFull   = (count == DEPTH_C);
  assign isEmpty  = (count == '0);

  // R6: level never exceeds the buffer size
  a_r6_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= DEPTH_C);
  // R9: a pop strobe only reaches the datapath with stored data
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |-> count != '0);
  // R5: write and read never share a cycle
  a_r5_no_concurrent: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.push && strobes.pop));
endmodule

// File: rtl/wm_result_fifo_ctrl.sv
module wm_result_fifo_ctrl
  import wm_result_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          resultValid,
  input  logic          rdPop,
  input  logic          burstEnd,
  input  logic          lostClr,
  input  logic [CW-1:0] cfgWatermark,
  input  logic [CW-1:0] count,
  input  logic          isFull,
  input  logic          isEmpty,
  output fifoStrobes_t  strobes,
  output logic          readBusy,
  output logic          lostFlag,
  output logic          irq
);
  logic dropNow;

  always_comb begin
    strobes.pop  = rdPop && !isEmpty;
    strobes.push = resultValid && !isFull && !rdPop && !readBusy;
    dropNow      = resultValid && !strobes.push;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readBusy <= 1'b0;
      lostFlag <= 1'b0;
    end else begin
      if (burstEnd)                               readBusy <= 1'b0;
      else if (strobes.pop && count == CW'(1))    readBusy <= 1'b0;
      else if (strobes.pop)                       readBusy <= 1'b1;
      lostFlag <= dropNow || (lostFlag && !lostClr);
    end
  end

  assign irq = (cfgWatermark != '0) && (count >= cfgWatermark);

  // R7: flag holds until cleared
  a_r7_lost_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (lostFlag && !lostClr) |=> lostFlag);
  // R5: a result during a burst sets the flag
  a_r5_busy_drop: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && readBusy) |=> lostFlag);
  // R8: burst never outlives the stored data
  a_r8_busy_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    readBusy |-> !isEmpty);
  // R3: a rising interrupt with a stable watermark follows a write
  a_r3_irq_rise: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(irq) && $stable(cfgWatermark)) |-> $past(strobes.push));
endmodule

// File: rtl/wm_result_fifo.sv
module wm_result_fifo
  import wm_result_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 24,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          resultValid,
  input  logic [DW-1:0] resultData,
  input  logic          rdPop,
  output logic [DW-1:0] rdData,
  input  logic          burstEnd,
  input  logic [CW-1:0] cfgWatermark,
  input  logic          lostClr,
  output logic [CW-1:0] level,
  output logic          fifoEmpty,
  output logic          readBusy,
  output logic          irq,
  output logic          lostFlag
);
  fifoStrobes_t strobes;
  logic isFull;

  wm_result_fifo_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .resultValid(resultValid), .rdPop(rdPop),
    .burstEnd(burstEnd), .lostClr(lostClr), .cfgWatermark(cfgWatermark),
    .count(level), .isFull(isFull), .isEmpty(fifoEmpty), .strobes(strobes),
    .readBusy(readBusy), .lostFlag(lostFlag), .irq(irq)
  );

  wm_result_fifo_dp #(.DEPTH(DEPTH), .DW(DW)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(resultData),
    .headData(rdData), .count(level), .isFull(isFull), .isEmpty(fifoEmpty)
  );

  // R4: a zero watermark keeps the interrupt low
  a_r4_irq_off: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWatermark == '0) |-> !irq);
  // R5: during a burst without pop the level is frozen
  a_r5_level_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (readBusy && !rdPop) |=> $stable(level));
endmodule

// File: tb/wm_result_fifo_test.sv
module wm_result_fifo_test;
  localparam int DEPTH = 16;
  localparam int DW    = 24;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic resultValid = 1'b0, rdPop = 1'b0, burstEnd = 1'b0, lostClr = 1'b0;
  logic [DW-1:0] resultData = '0;
  logic [CW-1:0] cfgWatermark = '0;
  logic [DW-1:0] rdData;
  logic [CW-1:0] level;
  logic fifoEmpty, readBusy, irq, lostFlag;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  wm_result_fifo #(.DEPTH(DEPTH), .DW(DW)) uut (
    .clk(clk), .rstN(rstN), .resultValid(resultValid), .resultData(resultData),
    .rdPop(rdPop), .rdData(rdData), .burstEnd(burstEnd),
    .cfgWatermark(cfgWatermark), .lostClr(lostClr), .level(level),
    .fifoEmpty(fifoEmpty), .readBusy(readBusy), .irq(irq), .lostFlag(lostFlag)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one clock: apply inputs, wait the edge, release strobes
  task automatic step(input logic v, input logic [DW-1:0] d, input logic p,
                      input logic e, input logic c);
    resultValid = v; resultData = d; rdPop = p; burstEnd = e; lostClr = c;
    @(posedge clk); #1;
    resultValid = 0; rdPop = 0; burstEnd = 0; lostClr = 0;
  endtask

  task automatic doReset();
    rstN = 0;
    step(0, '0, 0, 0, 0);
    step(0, '0, 0, 0, 0);
    rstN = 1;
  endtask

  task automatic t_reset();
    doReset();
    chk("R1 level", level, 0);
    chk("R1 empty", fifoEmpty, 1);
    chk("R1 irq", irq, 0);
    chk("R1 busy", readBusy, 0);
    chk("R1 lost", lostFlag, 0);
  endtask

  task automatic t_order();
    doReset();
    cfgWatermark = CW'(4);
    for (int i = 0; i < 3; i++) step(1, DW'(24'h100 + i), 0, 0, 0);
    chk("R3 irq below wm", irq, 0);
    chk("R2 level 3", level, 3);
    step(1, DW'(24'h103), 0, 0, 0);
    chk("R3 irq at wm", irq, 1);
    chk("R2 head oldest", rdData, 24'h100);
    step(0, '0, 1, 0, 0);
    chk("R3 irq below after pop", irq, 0);
    chk("R8 busy after first pop", readBusy, 1);
    for (int i = 1; i < 4; i++) begin
      chk("R2 order", rdData, 24'h100 + i);
      step(0, '0, 1, 0, 0);
    end
    chk("R8 busy off when empty", readBusy, 0);
    chk("R2 empty", fifoEmpty, 1);
  endtask

  task automatic t_busyDrop();
    doReset();
    cfgWatermark = CW'(2);
    step(1, 24'hA1, 0, 0, 0);
    step(1, 24'hB2, 0, 0, 0);
    step(0, '0, 1, 0, 0);
    chk("R8 busy", readBusy, 1);
    step(1, 24'hC3, 0, 0, 0);
    chk("R5 level frozen", level, 1);
    chk("R5 lost set", lostFlag, 1);
    step(0, '0, 0, 0, 0);
    chk("R7 lost held", lostFlag, 1);
    step(0, '0, 0, 0, 1);
    chk("R7 lost cleared", lostFlag, 0);
    step(0, '0, 0, 1, 0);
    chk("R8 busy off by burstEnd", readBusy, 0);
    step(1, 24'hD4, 0, 0, 0);
    chk("R5 accept after burst", level, 2);
    chk("R3 irq at wm 2", irq, 1);
    chk("R5 head", rdData, 24'hB2);
    step(0, '0, 1, 0, 0);
    chk("R5 next not dropped word", rdData, 24'hD4);
    step(0, '0, 1, 0, 0);
  endtask

  task automatic t_sameCycle();
    doReset();
    cfgWatermark = CW'(1);
    step(1, 24'h55, 0, 0, 0);
    chk("R5 head before", rdData, 24'h55);
    step(1, 24'h66, 1, 0, 0);
    chk("R5 same-cycle level", level, 0);
    chk("R5 same-cycle lost", lostFlag, 1);
    chk("R8 busy off after single pop", readBusy, 0);
    step(1, 24'h77, 0, 0, 0);
    step(0, '0, 1, 0, 0);
    step(1, 24'h88, 1, 0, 1);
    chk("R7 set wins over clear", lostFlag, 1);
  endtask

  task automatic t_full();
    doReset();
    cfgWatermark = '0;
    for (int i = 0; i < DEPTH; i++) step(1, DW'(24'h200 + i), 0, 0, 0);
    chk("R4 irq off at full", irq, 0);
    chk("R6 level full", level, DEPTH);
    chk("R6 lost clear before", lostFlag, 0);
    step(1, 24'hFFF, 0, 0, 0);
    chk("R6 level unchanged", level, DEPTH);
    chk("R6 lost set", lostFlag, 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R6 contents", rdData, 24'h200 + i);
      step(0, '0, 1, 0, 0);
    end
    chk("R6 drained", fifoEmpty, 1);
  endtask

  task automatic t_emptyPop();
    doReset();
    step(0, '0, 1, 0, 0);
    chk("R9 level", level, 0);
    chk("R9 busy", readBusy, 0);
  endtask

  initial begin
    #20000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    t_reset();
    t_order();
    t_busyDrop();
    t_sameCycle();
    t_full();
    t_emptyPop();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule